// File: doc/BRIEF.md
# Dual-Threshold Supply State Controller

This block decides the operating state of a device from two supply comparators. One threshold is low and marks the point where digital state can be trusted. The other is higher and marks the point where analog circuits can run. The block enables the analog section and the outputs. It asks non-volatile storage to load the shadowed settings the first time the supply clears the higher threshold, and it keeps a flag telling the rest of the chip whether those settings are valid. It also drives an active-high "not ready" status bit for the register interface.

A dip that stays between the two thresholds shuts down the analog section and the outputs, but the loaded settings are kept. When the supply comes back, operation resumes without another load. A dip below the lower threshold drops the settings, so the next rise triggers a new load. After each rise above the higher threshold, a programmable cycle delay must run out and the load must have completed before the status bit clears and the outputs turn on.

Top module: `supply_state_ctrl`

## Requirements
- R1: While reset is held, or while the supply is below the lower threshold, all enables and the load request are 0, the settings-valid flag is 0 and the not-ready bit is 1.
- R2: With the supply above the lower threshold but below the higher one, and no settings loaded, no load is requested and the not-ready bit stays 1.
- R3: The first rise above the higher threshold raises the load request and the analog enable 3 clock edges after the input changes (two synchroniser flops plus the state register). The outputs stay disabled during this time.
- R4: A load-done pulse received while the request is high sets the settings-valid flag and drops the request on the next edge.
- R5: Once the settings are valid, the not-ready bit falls and the output enable rises exactly 2+READY_DELAY_CYC edges after the higher-threshold input rises. One edge earlier both are still inactive.
- R6: If the load completes after the delay has run out, the not-ready bit stays 1 until the edge that registers load-done.
- R7: A drop below the higher threshold while staying above the lower one clears the analog and output enables and sets the not-ready bit. The settings-valid flag remains 1.
- R8: A recovery above the higher threshold with valid settings turns the analog enable back on 3 edges after the input rises, issues no new load request, and re-runs the full delay before the bit clears.
- R9: A drop below the lower threshold clears the settings-valid flag, and the next rise above the higher threshold requests a new load.
- R10: Any drop of the higher-threshold input, even for one cycle, restarts the delay from zero.
- R11: A load-done pulse while no load is requested has no effect on the settings-valid flag or any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lo_above | input | 1 | Comparator: supply above lower (digital) threshold, asynchronous |
| hi_above | input | 1 | Comparator: supply above higher (analog) threshold, asynchronous |
| recall_done | input | 1 | One-cycle pulse from storage: shadow load finished |
| recall_req | output | 1 | Request to load shadowed settings from storage |
| analog_en | output | 1 | Enable for the analog section |
| out_en | output | 1 | Enable for the device outputs |
| shadow_valid | output | 1 | Loaded settings are present (0 means working registers at defaults) |
| ready_n | output | 1 | Status bit: 1 while not fully functional |

## Verification
The bench steps the two comparator levels through a first power-up, a dip between the thresholds with recovery, a one-cycle glitch of the higher threshold, and a full drop below the lower one followed by a second power-up. Each sequence is sampled at exact edge counts, so an extra or missing synchroniser stage or an off-by-one delay shows up. A quick load separates the timer path from the load path. A load slower than the delay shows that both conditions are needed, and a stray load-done pulse shows that only a pending request is acknowledged. A count of load pulses separates a resume with retained settings from a fresh load.

// File: rtl/supply_ctrl_pkg.sv
// Shared types for the supply state controller.
package supply_ctrl_pkg;
    // Operating states of the supply controller.
    typedef enum logic [1:0] {
        PS_OFF    = 2'd0,   // no valid settings, analog and outputs off
        PS_RECALL = 2'd1,   // above high threshold, waiting for shadow load
        PS_RUN    = 2'd2,   // above high threshold, settings valid
        PS_HOLD   = 2'd3    // between thresholds, settings retained
    } pwr_state_t;
endpackage

// File: rtl/lvl_sync.sv
// Multi-flop synchroniser for a vector of independent level signals.
// Assumes: STAGES >= 2, each bit is a slow level with no relation to the others.
module lvl_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar gb = 0; gb < WIDTH; gb++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        // Shift the asynchronous level through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], async_i[gb]};
        end

        assign sync_o[gb] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/ready_timer.sv
// Saturating cycle counter: counts while run_i is high, clears when it drops.
// Assumes: DELAY_CYCLES >= 1.
module ready_timer #(
    parameter int DELAY_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(DELAY_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DELAY_CYCLES);

    logic [CNT_W-1:0] count_q;

    // Count up to the limit while enabled, restart from zero on any drop.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)   count_q <= '0;
        else if (count_q != LIMIT) count_q <= count_q + CNT_W'(1);
    end

    assign expired_o = (count_q == LIMIT);
endmodule

// File: rtl/pwr_fsm.sv
// Supply state machine: tracks retained settings across the two thresholds.
// Assumes: lo_ok_i and hi_ok_i are already synchronised; recall_done_i is a
// pulse meaningful only while a load is pending.
module pwr_fsm
    import supply_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lo_ok_i,
    input  logic       hi_ok_i,
    input  logic       recall_done_i,
    output pwr_state_t state_o
);
    pwr_state_t state_q, state_d;

    // Next-state decision from the threshold levels and the load handshake.
    always_comb begin
        state_d = state_q;
        if (!lo_ok_i) begin
            state_d = PS_OFF;
        end else begin
            unique case (state_q)
                PS_OFF:    if (hi_ok_i)        state_d = PS_RECALL;
                PS_RECALL: if (!hi_ok_i)       state_d = PS_OFF;
                           else if (recall_done_i) state_d = PS_RUN;
                PS_RUN:    if (!hi_ok_i)       state_d = PS_HOLD;
                PS_HOLD:   if (hi_ok_i)        state_d = PS_RUN;
                default:                       state_d = PS_OFF;
            endcase
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_OFF;
        else        state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/supply_state_ctrl.sv
// Top: two-threshold supply controller. Synchronises the comparators, runs
// the state machine and the ready delay, and decodes the enables.
// Assumes: comparator inputs are glitch-filtered levels; READY_DELAY_CYC
// equals 500 us at the block clock (50000 at 100 MHz).
module supply_state_ctrl
    import supply_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES     = 2,
    parameter int READY_DELAY_CYC = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lo_above,
    input  logic hi_above,
    input  logic recall_done,
    output logic recall_req,
    output logic analog_en,
    output logic out_en,
    output logic shadow_valid,
    output logic ready_n
);
    localparam int LVL_W = 2;

    logic [LVL_W-1:0] lvl_sync_q;
    logic             lo_sync, hi_sync;
    logic             delay_done;
    pwr_state_t       state;

    lvl_sync #(.STAGES(SYNC_STAGES), .WIDTH(LVL_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({hi_above, lo_above}),
        .sync_o  (lvl_sync_q)
    );

    assign lo_sync = lvl_sync_q[0];
    assign hi_sync = lvl_sync_q[1];

    pwr_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .lo_ok_i       (lo_sync),
        .hi_ok_i       (hi_sync),
        .recall_done_i (recall_done),
        .state_o       (state)
    );

    ready_timer #(.DELAY_CYCLES(READY_DELAY_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (hi_sync),
        .expired_o (delay_done)
    );

    // Decode enables and status from the state and the delay.
    always_comb begin
        recall_req   = (state == PS_RECALL);
        analog_en    = (state == PS_RECALL) || (state == PS_RUN);
        shadow_valid = (state == PS_RUN) || (state == PS_HOLD);
        out_en       = (state == PS_RUN) && delay_done;
        ready_n      = !((state == PS_RUN) && delay_done);
    end
endmodule

// File: rtl/supply_state_ctrl_chk.sv
// Property checker for supply_state_ctrl, attached by bind.
module supply_state_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic lo_s,
    input logic hi_s,
    input logic recall_done,
    input logic recall_req,
    input logic analog_en,
    input logic out_en,
    input logic shadow_valid,
    input logic ready_n
);
    // R3: a load is requested only while settings are absent, with analog on.
    a_r3_req_without_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |-> (!shadow_valid && analog_en));

    // R4: settings become valid only after an acknowledged request.
    a_r4_shadow_from_recall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shadow_valid) |-> $past(recall_req && recall_done));

    // R5: ready implies fully running.
    a_r5_ready_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_n |-> (out_en && analog_en && shadow_valid));

    // R7: a low high-threshold level shuts analog and ready next edge.
    a_r7_hold_when_hi_low: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_s |=> (!analog_en && ready_n));

    // R8: with settings valid, no fresh load is requested.
    a_r8_resume_no_recall: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_valid && hi_s) |=> !recall_req);

    // R9: below the lower threshold settings are dropped.
    a_r9_clear_below_lo: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_s |=> !shadow_valid);

    // R2: no request while below the higher threshold.
    a_r2_no_req_below_hi: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_s |=> !recall_req);
endmodule

bind supply_state_ctrl supply_state_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lo_s         (lo_sync),
    .hi_s         (hi_sync),
    .recall_done  (recall_done),
    .recall_req   (recall_req),
    .analog_en    (analog_en),
    .out_en       (out_en),
    .shadow_valid (shadow_valid),
    .ready_n      (ready_n)
);

// File: tb/supply_state_ctrl_bench.sv
// Scoreboard bench: driver queues expected output vectors
// {out_en, analog_en, recall_req, shadow_valid, ready_n}; a monitor compares.
module supply_state_ctrl_bench;
    localparam int DLY = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lo_above = 1'b0;
    logic hi_above = 1'b0;
    logic resp_done = 1'b0;
    logic manual_done = 1'b0;
    logic recall_done;
    logic recall_req, analog_en, out_en, shadow_valid, ready_n;

    int checks = 0;
    int errors = 0;
    int recall_cnt = 0;
    int recall_lat = 2;
    bit finished = 1'b0;

    logic [4:0] exp_q[$];
    string      tag_q[$];
    event       mon_ev;

    assign recall_done = resp_done | manual_done;

    always #5 clk = ~clk;

    supply_state_ctrl #(.SYNC_STAGES(2), .READY_DELAY_CYC(DLY)) u_supply_state_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .lo_above     (lo_above),
        .hi_above     (hi_above),
        .recall_done  (recall_done),
        .recall_req   (recall_req),
        .analog_en    (analog_en),
        .out_en       (out_en),
        .shadow_valid (shadow_valid),
        .ready_n      (ready_n)
    );

    // Storage model: answer a pending request after recall_lat cycles.
    initial forever begin
        @(negedge clk);
        if (recall_req) begin
            repeat (recall_lat) @(negedge clk);
            resp_done = 1'b1;
            recall_cnt++;
            @(negedge clk);
            resp_done = 1'b0;
        end
    end

    // Monitor: pop expected vectors and compare with the outputs.
    initial forever begin
        @(mon_ev);
        while (exp_q.size() > 0) begin
            logic [4:0] e;
            logic [4:0] a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {out_en, analog_en, recall_req, shadow_valid, ready_n};
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s actual=%b expected=%b", t, a, e);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic [4:0] e);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        -> mon_ev;
        #1;
    endtask

    task automatic check_cnt(input string tag, input int exp);
        checks++;
        if (recall_cnt != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, recall_cnt, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        expect_out("R1 in reset", 5'b00001);
        rst_n = 1'b1;
        step(4);
        expect_out("R1 below lower after reset", 5'b00001);

        lo_above = 1'b1;
        step(5);
        expect_out("R2 between thresholds, no settings", 5'b00001);

        // R11: stray load-done ignored
        manual_done = 1'b1;
        step(1);
        manual_done = 1'b0;
        step(3);
        expect_out("R11 stray done ignored", 5'b00001);

        // First power-up, quick load
        recall_lat = 2;
        hi_above = 1'b1;
        step(2);
        expect_out("R3 not yet requested at edge 2", 5'b00001);
        step(1);
        expect_out("R3 request and analog at edge 3", 5'b01101);
        step(3);
        expect_out("R4 settings valid, request dropped", 5'b01011);
        step(DLY + 1 - 6);
        expect_out("R5 still not ready at edge 1+DLY", 5'b01011);
        step(1);
        expect_out("R5 ready at edge 2+DLY", 5'b11010);
        check_cnt("R3 one load issued", 1);

        // Dip between thresholds
        hi_above = 1'b0;
        step(5);
        expect_out("R7 dip keeps settings", 5'b00011);

        // Recovery
        hi_above = 1'b1;
        step(2);
        expect_out("R8 analog still off at edge 2", 5'b00011);
        step(1);
        expect_out("R8 analog back at edge 3", 5'b01011);
        step(DLY + 1 - 3);
        expect_out("R8 delay re-run, not ready at 1+DLY", 5'b01011);
        step(1);
        expect_out("R8 ready at edge 2+DLY", 5'b11010);
        check_cnt("R8 no new load", 1);

        // One-cycle glitch of the higher threshold
        hi_above = 1'b0;
        step(1);
        hi_above = 1'b1;
        step(DLY + 1);
        expect_out("R10 restarted delay, not ready at 1+DLY", 5'b01011);
        step(1);
        expect_out("R10 ready at edge 2+DLY", 5'b11010);

        // Drop below the lower threshold
        hi_above = 1'b0;
        lo_above = 1'b0;
        step(5);
        expect_out("R9 settings dropped", 5'b00001);
        lo_above = 1'b1;
        step(5);
        expect_out("R9 between thresholds after drop", 5'b00001);

        // Second power-up with a slow load
        recall_lat = DLY + 10;
        hi_above = 1'b1;
        step(3);
        expect_out("R9 new load requested", 5'b01101);
        step(DLY + 2 - 3);
        expect_out("R6 delay done but load pending", 5'b01101);
        step(3 + (DLY + 10) - (DLY + 2));
        expect_out("R6 still pending at done edge", 5'b01101);
        step(1);
        expect_out("R6 ready on load-done edge", 5'b11010);
        check_cnt("R9 second load issued", 2);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule